// File: doc/BRIEF.md
# Base Address Window Decoder

This block takes the base address registers of one configurable device and turns them into checked address windows. There are six standard base registers and one expansion-ROM base register. A parameter fixes the size of each region as a power of two, or as zero when the region is unused, and says whether it sits in I/O or memory space. Software programs the registers and a two-bit command register through a simple word-write port. The block keeps a registered decode result for every region: a valid flag and the size-aligned base address.

Each cycle the block compares an incoming lookup address and space selector against the windows it holds. It raises a hit bit for every valid window of the same space that contains the address. When the recomputed base of a region differs from the one it held before, it pulses a change flag for that region for one cycle. This includes a window that turns invalid. Logic downstream uses these pulses to update its own address map.

Top module: `bar_window_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, every window reads invalid with base all ones, and no change or hit bit is set.
- R2: Writes are whole 32-bit words at a byte offset. The command register is at 0x04, with bit 0 as the I/O-space enable and bit 1 as the memory-space enable. Standard register n (n = 0..5) is at 0x10 + 4n and the ROM register is at 0x30. A write to any other offset changes no output.
- R3: A region whose size parameter is zero never becomes valid and never pulses its change flag.
- R4: An I/O region is valid only while the I/O enable is set. A memory region, including the ROM, is valid only while the memory enable is set.
- R5: The reported base is the register value with its low log2(size) bits cleared. An invalid window reports a base of all ones.
- R6: An I/O window is invalid when its base is zero, when base + size − 1 does not exceed the base, or when base + size − 1 is 0x10000 or more.
- R7: A memory window is invalid when its base is zero, when base + size − 1 does not exceed the base, or when base + size − 1 is all ones.
- R8: The ROM window is valid only while bit 0 of its register is set. That bit never appears in the reported base.
- R9: A region's change bit is high for exactly one cycle when its reported base differs from the one it reported before. Rewriting a value that keeps the base unchanged gives no pulse.
- R10: A hit bit is set only when its window is valid, the lookup space matches the region type (lookup I/O select 1 for I/O), and the address lies in base .. base + size − 1. Hit is combinational from the held windows.
- R11: A write sampled at clock edge k first shows on the valid, base and change outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_ofs | input | 8 | Byte offset of the written register |
| wr_data | input | 32 | Write data |
| lk_addr | input | 32 | Address to look up |
| lk_io | input | 1 | Lookup space: 1 for I/O, 0 for memory |
| win_valid | output | 7 | Per-region valid flag, ROM is bit 6 |
| win_base | output | 224 | Per-region base, region i in bits 32i+31..32i |
| win_chg | output | 7 | One-cycle pulse when a region's base changes |
| hit | output | 7 | Per-region lookup hit |

## Verification
Some properties are checked on every cycle. A valid base is always size-aligned, an invalid one is all ones, and a valid window obeys the zero-base, wrap and 64K rules of its space. Validity also follows the enable bits and the ROM enable bit from the previous cycle, and each change pulse matches a real move of the held base. Some behaviour only the directed scenarios can show: which offset reaches which register, the exact aligned values, the one-cycle latency from a write, the absence of a pulse on a rewrite that changes nothing, and where a hit window ends.

// File: rtl/bawd_pkg.sv
// Shared constants for the base address window decoder.
// Assumes 32-bit configuration words and byte offsets below 0x100.
package bawd_pkg;
    localparam int NREG        = 7;        // six standard regions plus ROM
    localparam int ROM_IDX     = 6;        // ROM region index
    localparam int CMD_IO_BIT  = 0;        // command bit: I/O space enable
    localparam int CMD_MEM_BIT = 1;        // command bit: memory space enable
    localparam logic [7:0] OFS_CMD  = 8'h04;
    localparam logic [7:0] OFS_BAR0 = 8'h10;
    localparam logic [7:0] OFS_ROM  = 8'h30;
    localparam logic [31:0] IO_TOP  = 32'h0001_0000; // first address beyond I/O space
endpackage

// File: rtl/bawd_regs.sv
// Register storage: command enables and the seven base registers.
// Assumes whole-word writes; size-zero regions keep their register at zero.
// Stores the size mask and the type bit, as a configuration space does.
module bawd_regs
    import bawd_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] SIZE [NREG] = '{default: '0},
    parameter logic [NREG-1:0] IS_IO = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_ofs,
    input  logic [AW-1:0]      wr_data,
    output logic               cmd_io,
    output logic               cmd_mem,
    output logic [NREG*AW-1:0] bar_flat
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    // Command register: keep only the two space enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_io  <= 1'b0;
            cmd_mem <= 1'b0;
        end else if (wr_en && wr_ofs == OFS_CMD) begin
            cmd_io  <= wr_data[CMD_IO_BIT];
            cmd_mem <= wr_data[CMD_MEM_BIT];
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_bar
        localparam logic [7:0] OFS = (i == ROM_IDX) ? OFS_ROM : OFS_BAR0 + 8'(4 * i);
        localparam logic [AW-1:0] MASK = ~(SIZE[i] - ONE);
        logic [AW-1:0] bar_q;

        // Base register: masked store; ROM keeps its enable bit, others carry the type bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bar_q <= '0;
            end else if (wr_en && wr_ofs == OFS && SIZE[i] != '0) begin
                if (i == ROM_IDX)
                    bar_q <= wr_data & (MASK | ONE);
                else
                    bar_q <= (wr_data & MASK) | {{(AW-1){1'b0}}, IS_IO[i]};
            end
        end

        assign bar_flat[i*AW +: AW] = bar_q;

        a_r3_unused_reg_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (SIZE[i] == '0) |-> (bar_q == '0));
    end
endmodule

// File: rtl/bawd_window.sv
// Per-region window evaluation and hold register.
// Assumes SIZE is zero or a power of two of at least 16 and AW >= 17.
// Output base is all ones when the window is invalid.
module bawd_window
    import bawd_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] SIZE = '0,
    parameter bit IS_IO = 1'b0,
    parameter bit IS_ROM = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_io,
    input  logic          cmd_mem,
    input  logic [AW-1:0] bar,
    output logic          valid_q,
    output logic [AW-1:0] base_q,
    output logic          chg_q
);
    localparam logic [AW-1:0] ONE  = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] MASK = ~(SIZE - ONE);
    localparam logic [AW-1:0] TOP  = AW'(IO_TOP);

    logic [AW-1:0] cand, last, next_base;
    logic          enabled, sane;

    // Candidate window and its acceptance rules.
    always_comb begin
        cand    = bar & MASK;
        last    = cand + SIZE - ONE;
        enabled = (SIZE != '0) &&
                  (IS_IO ? cmd_io : (cmd_mem && (!IS_ROM || bar[0])));
        if (IS_IO)
            sane = (last > cand) && (cand != '0) && (last < TOP);
        else
            sane = (last > cand) && (cand != '0) && (last != '1);
        next_base = (enabled && sane) ? cand : '1;
    end

    // Hold the window and flag any movement of its base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            base_q  <= '1;
            chg_q   <= 1'b0;
        end else begin
            valid_q <= enabled && sane;
            base_q  <= next_base;
            chg_q   <= (next_base != base_q);
        end
    end

    a_r5_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ((base_q & ~MASK) == '0));
    a_r5_invalid_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> (base_q == '1));
    a_r4_space_enable: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(IS_IO ? cmd_io : cmd_mem));
    a_r6_io_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && IS_IO) |-> (base_q != '0 && (base_q + SIZE - ONE) < TOP));
    a_r7_mem_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !IS_IO) |-> (base_q != '0 && (base_q + SIZE - ONE) != '1));
    a_r8_rom_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && IS_ROM) |-> $past(bar[0]));
    a_r9_pulse_tracks_base: assert property (@(posedge clk) disable iff (!rst_n)
        chg_q == (base_q != $past(base_q)));
    a_r3_unused_never_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (SIZE == '0) |-> (!valid_q && !chg_q));
endmodule

// File: rtl/bawd_hit.sv
// Lookup comparator: matches an address and space against held windows.
// Assumes valid windows never wrap, so an offset compare is exact.
module bawd_hit
    import bawd_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] SIZE [NREG] = '{default: '0},
    parameter logic [NREG-1:0] IS_IO = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG-1:0]    valid,
    input  logic [NREG*AW-1:0] base_flat,
    input  logic [AW-1:0]      lk_addr,
    input  logic               lk_io,
    output logic [NREG-1:0]    hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        logic [AW-1:0] b;
        assign b = base_flat[i*AW +: AW];

        // Range and space match for one region.
        always_comb begin
            hit[i] = valid[i] && (lk_io == IS_IO[i]) &&
                     (lk_addr >= b) && ((lk_addr - b) < SIZE[i]);
        end

        a_r10_hit_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |-> (valid[i] && lk_io == IS_IO[i]));
    end
endmodule

// File: rtl/bar_window_decoder.sv
// Top: base address registers in, validated decode windows and hits out.
// Region sizes and types are fixed at build time; the ROM region is always memory.
module bar_window_decoder
    import bawd_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] REGION_SIZE [NREG] =
        '{32'd16, 32'd4096, 32'd0, 32'd256, 32'd16, 32'd0, 32'd65536},
    parameter logic [NREG-1:0] REGION_IO = 7'b000_1001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_ofs,
    input  logic [AW-1:0]      wr_data,
    input  logic [AW-1:0]      lk_addr,
    input  logic               lk_io,
    output logic [NREG-1:0]    win_valid,
    output logic [NREG*AW-1:0] win_base,
    output logic [NREG-1:0]    win_chg,
    output logic [NREG-1:0]    hit
);
    localparam logic [NREG-1:0] IO_EFF = REGION_IO & ~(NREG'(1) << ROM_IDX);

    logic               cmd_io, cmd_mem;
    logic [NREG*AW-1:0] bar_flat;

    bawd_regs #(.AW(AW), .SIZE(REGION_SIZE), .IS_IO(IO_EFF)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs),
        .wr_data(wr_data), .cmd_io(cmd_io), .cmd_mem(cmd_mem), .bar_flat(bar_flat)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_win
        bawd_window #(
            .AW(AW), .SIZE(REGION_SIZE[i]), .IS_IO(IO_EFF[i]), .IS_ROM(i == ROM_IDX)
        ) u_win (
            .clk(clk), .rst_n(rst_n), .cmd_io(cmd_io), .cmd_mem(cmd_mem),
            .bar(bar_flat[i*AW +: AW]), .valid_q(win_valid[i]),
            .base_q(win_base[i*AW +: AW]), .chg_q(win_chg[i])
        );
    end

    bawd_hit #(.AW(AW), .SIZE(REGION_SIZE), .IS_IO(IO_EFF)) u_hit (
        .clk(clk), .rst_n(rst_n), .valid(win_valid), .base_flat(win_base),
        .lk_addr(lk_addr), .lk_io(lk_io), .hit(hit)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (win_valid == '0 && win_chg == '0));
endmodule

// File: tb/bar_window_decoder_test.sv
`timescale 1ns/1ps
module bar_window_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_ofs = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] lk_addr = '0;
    logic        lk_io = 1'b0;
    logic [6:0]  win_valid, win_chg, hit;
    logic [223:0] win_base;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bar_window_decoder uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ofs(wr_ofs), .wr_data(wr_data),
        .lk_addr(lk_addr), .lk_io(lk_io), .win_valid(win_valid), .win_base(win_base),
        .win_chg(win_chg), .hit(hit)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] base_of(input int i);
        return win_base[i*32 +: 32];
    endfunction

    // Drive one write so it is sampled at the next edge; return at the following negedge.
    task automatic wr_only(input logic [7:0] ofs, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_ofs = ofs; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Write and wait until the recomputed windows are visible.
    task automatic wr(input logic [7:0] ofs, input logic [31:0] data);
        wr_only(ofs, data);
        @(negedge clk);
    endtask

    task automatic look(input logic [31:0] a, input logic io);
        lk_addr = a; lk_io = io;
        #1;
    endtask

    task automatic t_reset;
        check("R1", "valid", 32'(win_valid), 32'h0);
        check("R1", "chg", 32'(win_chg), 32'h0);
        look(32'h0, 1'b0);
        check("R1", "hit", 32'(hit), 32'h0);
        check("R1", "base0", base_of(0), 32'hFFFF_FFFF);
        check("R1", "base_rom", base_of(6), 32'hFFFF_FFFF);
    endtask

    task automatic t_io_window;
        wr(8'h10, 32'h0000_1234);
        check("R4", "io disabled valid", 32'(win_valid), 32'h0);
        check("R4", "io disabled chg", 32'(win_chg), 32'h0);
        wr_only(8'h04, 32'h1);
        check("R11", "not yet valid", 32'(win_valid), 32'h0);
        @(negedge clk);
        check("R4", "io enabled valid", 32'(win_valid), 32'h01);
        check("R5", "aligned base0", base_of(0), 32'h0000_1230);
        check("R9", "pulse on enable", 32'(win_chg), 32'h01);
        @(negedge clk);
        check("R9", "pulse one cycle", 32'(win_chg), 32'h0);
        look(32'h0000_123F, 1'b1);
        check("R10", "top of io window", 32'(hit), 32'h01);
        look(32'h0000_1240, 1'b1);
        check("R10", "past io window", 32'(hit), 32'h0);
        look(32'h0000_1230, 1'b0);
        check("R10", "wrong space", 32'(hit), 32'h0);
        wr(8'h10, 32'h0000_1238);
        check("R9", "same base no pulse", 32'(win_chg), 32'h0);
        wr(8'h10, 32'h0000_0000);
        check("R6", "zero base invalid", 32'(win_valid), 32'h0);
        check("R9", "pulse on invalid", 32'(win_chg), 32'h01);
        check("R5", "invalid ones", base_of(0), 32'hFFFF_FFFF);
    endtask

    task automatic t_io_limits;
        wr(8'h1C, 32'h0000_FF05);
        check("R6", "end at ffff valid", 32'(win_valid), 32'h08);
        check("R2", "region3 base", base_of(3), 32'h0000_FF00);
        wr(8'h1C, 32'h0001_0000);
        check("R6", "end beyond 64K", 32'(win_valid), 32'h0);
        wr(8'h1C, 32'hFFFF_FF00);
        check("R6", "end all ones io", 32'(win_valid), 32'h0);
        check("R9", "no pulse invalid to invalid", 32'(win_chg), 32'h0);
    endtask

    task automatic t_mem_window;
        wr(8'h14, 32'h8000_0123);
        check("R4", "mem disabled", 32'(win_valid), 32'h0);
        wr(8'h04, 32'h3);
        check("R4", "mem enabled", 32'(win_valid), 32'h02);
        check("R5", "base1", base_of(1), 32'h8000_0000);
        check("R9", "pulse region1", 32'(win_chg), 32'h02);
        look(32'h8000_0FFF, 1'b0);
        check("R10", "top of mem window", 32'(hit), 32'h02);
        look(32'h8000_1000, 1'b0);
        check("R10", "past mem window", 32'(hit), 32'h0);
        wr(8'h14, 32'hFFFF_F000);
        check("R7", "end all ones mem", 32'(win_valid), 32'h0);
        wr(8'h14, 32'hFFFF_E000);
        check("R7", "just below top", base_of(1), 32'hFFFF_E000);
        wr(8'h20, 32'h0000_0010);
        check("R2", "region4 valid", 32'(win_valid), 32'h12);
        check("R5", "base4", base_of(4), 32'h0000_0010);
    endtask

    task automatic t_rom;
        wr(8'h30, 32'hC000_0000);
        check("R8", "rom bit clear", 32'(win_valid), 32'h12);
        check("R8", "rom no pulse", 32'(win_chg), 32'h0);
        wr(8'h30, 32'hC000_0001);
        check("R8", "rom bit set", 32'(win_valid), 32'h52);
        check("R8", "rom base", base_of(6), 32'hC000_0000);
        look(32'hC000_FFFF, 1'b0);
        check("R10", "rom hit", 32'(hit), 32'h40);
        wr(8'h04, 32'h1);
        check("R4", "mem off", 32'(win_valid), 32'h0);
        check("R9", "three pulses", 32'(win_chg), 32'h52);
    endtask

    task automatic t_ignored;
        wr(8'h04, 32'h3);
        check("R4", "mem back on", 32'(win_valid), 32'h52);
        wr(8'h18, 32'h0000_4000);
        check("R3", "unused region valid", 32'(win_valid), 32'h52);
        check("R3", "unused region chg", 32'(win_chg), 32'h0);
        check("R3", "unused base", base_of(2), 32'hFFFF_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        check("R2", "stray offset valid", 32'(win_valid), 32'h52);
        check("R2", "stray offset chg", 32'(win_chg), 32'h0);
        check("R2", "stray offset base1", base_of(1), 32'hFFFF_E000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_io_window;
        t_io_limits;
        t_mem_window;
        t_rom;
        t_ignored;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule